// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block guards the two bridge channels of a motor gate driver. Each channel reports an over-threshold flag from its switch voltage-drop comparator and a predriver fault flag. The chip as a whole reports an overtemperature flag and a supply undervoltage flag. From these inputs, a sleep input and a two-bit deglitch-time code, the block decides when each bridge must be switched off. It holds a status bit for each fault and drives an active-low fault pin.

Overcurrent and predriver faults belong to one channel. Each one switches off only that channel, and its bit stays set until the register interface pulses a write-zero clear strobe or the block is reset. An overcurrent counts only when the flag holds for longer than the selected deglitch window. Thermal and undervoltage faults switch off both channels and clear themselves when the condition goes away. The one exception is that undervoltage cannot clear while the part is asleep.

All inputs are assumed to be already synchronous to `clk`. Every status bit and every disable output changes on the clock edge that samples the input causing the change.

Top module: `motor_fault_sup`

## Requirements
- R1: After reset, every status bit is 0, `fault_n_o` is 1, and with `sleep_n_i` high both `bridge_off_o` bits are 0.
- R2: The deglitch window is DEG_BASE shifted left by `deg_code_i`: code 0 gives 1x, code 1 gives 2x, code 2 gives 4x and code 3 gives 8x. A channel's overcurrent bit sets on the clock edge at which `ovr_i` has been sampled high on window+1 consecutive edges. If the flag is low on any edge before that, the count restarts from zero.
- R3: A recognised overcurrent sets `ocp_o[i]` and raises `bridge_off_o[i]` for that channel only. The bit holds after the flag drops, until `clr_ocp_i[i]` is sampled high. The clear strobe also restarts that channel's deglitch count, so a flag that is still high sets the bit again one full window later.
- R4: When `pdf_flag_i[i]` is sampled high, `pdf_o[i]` and `bridge_off_o[i]` are set for that channel only. The bit clears only on `clr_pdf_i[i]`. If the flag and the clear arrive on the same edge, the flag wins.
- R5: `ot_o` follows `ot_i` one edge later. While `ot_o` is set, both bridges are off. Both bridges turn back on at the edge where `ot_o` clears.
- R6: `uv_o` sets when `uv_i` is sampled high and forces both bridges off. It clears on the first edge where `uv_i` is low and `sleep_n_i` is high, and it holds while `sleep_n_i` is low.
- R7: One edge after `sleep_n_i` is sampled low, both bridges are off. Sleep does not change the latched overcurrent or predriver bits.
- R8: `fault_n_o` is 0 exactly while at least one status bit is set. It returns to 1 at the same edge where the last fault-driven disable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n_i | input | 1 | Low puts the part to sleep |
| deg_code_i | input | 2 | Deglitch window select |
| ovr_i | input | NCH | Per-channel switch voltage-drop over-threshold flag |
| pdf_flag_i | input | NCH | Per-channel predriver fault flag |
| ot_i | input | 1 | Overtemperature flag |
| uv_i | input | 1 | Supply undervoltage flag |
| clr_ocp_i | input | NCH | Write-zero strobe for the overcurrent bits |
| clr_pdf_i | input | NCH | Write-zero strobe for the predriver bits |
| bridge_off_o | output | NCH | Per-channel bridge disable |
| ocp_o | output | NCH | Latched overcurrent status |
| pdf_o | output | NCH | Latched predriver status |
| ot_o | output | 1 | Overtemperature status |
| uv_o | output | 1 | Undervoltage status |
| fault_n_o | output | 1 | Active-low fault pin |

## Verification
The assertions assume that every flag, clear strobe and the sleep input are synchronous single-bit levels that settle before each edge. They also assume that a clear strobe lasts one cycle when the bench means a single write. The stimulus changes inputs only on falling edges and drops each clear strobe after one cycle. It moves `deg_code_i` only while no over-threshold flag is high, so each window is measured against one fixed code. Over-threshold flags are held for exactly window and window+1 edges to bracket the qualification edge, and a one-cycle dip is inserted to show that the count restarts.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  typedef logic [1:0] deg_code_t;

  // Window length in clock cycles for a given base and code.
  function automatic int unsigned deg_cycles(input int unsigned base, input deg_code_t code);
    return base << code;
  endfunction

endpackage

// File: rtl/fsup_deglitch.sv
module fsup_deglitch
  import fsup_pkg::*;
#(
  parameter int unsigned BASE = 105
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      flag_i,
  input  logic      restart_i,
  input  deg_code_t code_i,
  output logic      hit_o
);

  localparam int unsigned MAXC = BASE * 8;
  localparam int          CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    lim   = CW'(deg_cycles(BASE, code_i));
    hit_o = flag_i && !restart_i && (cnt_q >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst || restart_i || !flag_i) begin
      cnt_q <= '0;
    end else if (cnt_q < lim) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the running count never passes the longest window
  a_r2_cnt_cap: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAXC));

endmodule

// File: rtl/fsup_chan_latch.sv
module fsup_chan_latch
  import fsup_pkg::*;
#(
  parameter int unsigned BASE = 105
) (
  input  logic      clk,
  input  logic      rst,
  input  deg_code_t code_i,
  input  logic      ovr_i,
  input  logic      pdf_i,
  input  logic      clr_ocp_i,
  input  logic      clr_pdf_i,
  output logic      ocp_o,
  output logic      pdf_o
);

  logic hit;
  logic ocp_q;
  logic pdf_q;

  fsup_deglitch #(.BASE(BASE)) u_deg (
    .clk       (clk),
    .rst       (rst),
    .flag_i    (ovr_i),
    .restart_i (clr_ocp_i),
    .code_i    (code_i),
    .hit_o     (hit)
  );

  // Overcurrent latch: a clear also restarts the window, so it wins here.
  always_ff @(posedge clk) begin
    if (rst) begin
      ocp_q <= 1'b0;
    end else if (hit) begin
      ocp_q <= 1'b1;
    end else if (clr_ocp_i) begin
      ocp_q <= 1'b0;
    end
  end

  // Predriver latch: a live flag beats a clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      pdf_q <= 1'b0;
    end else if (pdf_i) begin
      pdf_q <= 1'b1;
    end else if (clr_pdf_i) begin
      pdf_q <= 1'b0;
    end
  end

  assign ocp_o = ocp_q;
  assign pdf_o = pdf_q;

  // R2: an overcurrent bit only rises after a sampled-high flag
  a_r2_rise_needs_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(ocp_q) |-> $past(ovr_i));

  // R3: a set overcurrent bit survives any cycle without a clear
  a_r3_ocp_hold: assert property (@(posedge clk) disable iff (rst)
    (ocp_q && !clr_ocp_i) |=> ocp_q);

  // R4: a sampled predriver flag always leaves the bit set
  a_r4_pdf_set: assert property (@(posedge clk) disable iff (rst)
    pdf_i |=> pdf_q);

endmodule

// File: rtl/fsup_global.sv
module fsup_global (
  input  logic clk,
  input  logic rst,
  input  logic ot_i,
  input  logic uv_i,
  input  logic sleep_n_i,
  output logic ot_o,
  output logic uv_o,
  output logic asleep_o
);

  logic ot_q;
  logic uv_q;
  logic slp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ot_q  <= 1'b0;
      uv_q  <= 1'b0;
      slp_q <= 1'b0;
    end else begin
      ot_q  <= ot_i;
      slp_q <= !sleep_n_i;
      if (uv_i) begin
        uv_q <= 1'b1;
      end else if (sleep_n_i) begin
        uv_q <= 1'b0;
      end
    end
  end

  assign ot_o     = ot_q;
  assign uv_o     = uv_q;
  assign asleep_o = slp_q;

  // R5: thermal status tracks its flag with one edge of delay
  a_r5_ot_set: assert property (@(posedge clk) disable iff (rst)
    ot_i |=> ot_q);
  a_r5_ot_clear: assert property (@(posedge clk) disable iff (rst)
    !ot_i |=> !ot_q);

  // R6: undervoltage status cannot drop while asleep
  a_r6_uv_sleep_hold: assert property (@(posedge clk) disable iff (rst)
    (uv_q && !sleep_n_i) |=> uv_q);

endmodule

// File: rtl/motor_fault_sup.sv
module motor_fault_sup
  import fsup_pkg::*;
#(
  parameter int unsigned NCH      = 2,
  parameter int unsigned DEG_BASE = 105
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sleep_n_i,
  input  logic [1:0]     deg_code_i,
  input  logic [NCH-1:0] ovr_i,
  input  logic [NCH-1:0] pdf_flag_i,
  input  logic           ot_i,
  input  logic           uv_i,
  input  logic [NCH-1:0] clr_ocp_i,
  input  logic [NCH-1:0] clr_pdf_i,
  output logic [NCH-1:0] bridge_off_o,
  output logic [NCH-1:0] ocp_o,
  output logic [NCH-1:0] pdf_o,
  output logic           ot_o,
  output logic           uv_o,
  output logic           fault_n_o
);

  logic [NCH-1:0] ocp_st;
  logic [NCH-1:0] pdf_st;
  logic           ot_st;
  logic           uv_st;
  logic           asleep;
  logic           global_off;

  fsup_global u_glob (
    .clk       (clk),
    .rst       (rst),
    .ot_i      (ot_i),
    .uv_i      (uv_i),
    .sleep_n_i (sleep_n_i),
    .ot_o      (ot_st),
    .uv_o      (uv_st),
    .asleep_o  (asleep)
  );

  assign global_off = asleep | ot_st | uv_st;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    fsup_chan_latch #(.BASE(DEG_BASE)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .code_i    (deg_code_t'(deg_code_i)),
      .ovr_i     (ovr_i[ch]),
      .pdf_i     (pdf_flag_i[ch]),
      .clr_ocp_i (clr_ocp_i[ch]),
      .clr_pdf_i (clr_pdf_i[ch]),
      .ocp_o     (ocp_st[ch]),
      .pdf_o     (pdf_st[ch])
    );
    assign bridge_off_o[ch] = global_off | ocp_st[ch] | pdf_st[ch];
  end

  assign ocp_o     = ocp_st;
  assign pdf_o     = pdf_st;
  assign ot_o      = ot_st;
  assign uv_o      = uv_st;
  assign fault_n_o = !((|ocp_st) | (|pdf_st) | ot_st | uv_st);

  // R7: a sampled sleep request turns every bridge off
  a_r7_sleep_off: assert property (@(posedge clk) disable iff (rst)
    !sleep_n_i |=> (&bridge_off_o));

  // R8: a thermal flag always pulls the fault pin low
  a_r8_pin_on_ot: assert property (@(posedge clk) disable iff (rst)
    ot_i |=> !fault_n_o);

  // R8: the pin is never released while a bridge is off for a fault
  a_r8_pin_vs_off: assert property (@(posedge clk) disable iff (rst)
    (fault_n_o && !asleep) |-> (bridge_off_o == '0));

endmodule

// File: tb/motor_fault_sup_tb.sv
module motor_fault_sup_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 2;
  localparam int BASE       = 4;

  typedef struct {
    string    req;
    logic [1:0] dis;
    logic [1:0] ocp;
    logic [1:0] pdf;
    logic     ot;
    logic     uv;
    logic     fn;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           sleep_n = 1'b1;
  logic [1:0]     deg = 2'd0;
  logic [NCH-1:0] ovr = '0;
  logic [NCH-1:0] pdf = '0;
  logic           ot = 1'b0;
  logic           uv = 1'b0;
  logic [NCH-1:0] clr_ocp = '0;
  logic [NCH-1:0] clr_pdf = '0;
  logic [NCH-1:0] bridge_off;
  logic [NCH-1:0] ocp_st;
  logic [NCH-1:0] pdf_st;
  logic           ot_st;
  logic           uv_st;
  logic           fault_n;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // Expected model state, kept from the requirements
  logic [1:0] e_ocp = '0;
  logic [1:0] e_pdf = '0;
  logic       e_ot  = 1'b0;
  logic       e_uv  = 1'b0;
  logic       e_slp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  motor_fault_sup #(.NCH(NCH), .DEG_BASE(BASE)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .sleep_n_i    (sleep_n),
    .deg_code_i   (deg),
    .ovr_i        (ovr),
    .pdf_flag_i   (pdf),
    .ot_i         (ot),
    .uv_i         (uv),
    .clr_ocp_i    (clr_ocp),
    .clr_pdf_i    (clr_pdf),
    .bridge_off_o (bridge_off),
    .ocp_o        (ocp_st),
    .pdf_o        (pdf_st),
    .ot_o         (ot_st),
    .uv_o         (uv_st),
    .fault_n_o    (fault_n)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  // Push the state expected right after the coming rising edge.
  task automatic expect_now(input string req);
    exp_t e;
    e.req = req;
    for (int i = 0; i < NCH; i++) begin
      e.dis[i] = e_slp | e_ot | e_uv | e_ocp[i] | e_pdf[i];
    end
    e.ocp = e_ocp;
    e.pdf = e_pdf;
    e.ot  = e_ot;
    e.uv  = e_uv;
    e.fn  = !((|e_ocp) | (|e_pdf) | e_ot | e_uv);
    q.push_back(e);
  endtask

  // Monitor: compare one expected item per rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        logic [8:0] act;
        logic [8:0] exv;
        e   = q.pop_front();
        act = {bridge_off, ocp_st, pdf_st, ot_st, uv_st, fault_n};
        exv = {e.dis, e.ocp, e.pdf, e.ot, e.uv, e.fn};
        n_chk++;
        if (act !== exv) begin
          n_fail++;
          $display("FAIL %s: actual {off,ocp,pdf,ot,uv,fault_n}=%b expected=%b", e.req, act, exv);
        end
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Hold a channel's flag high for window+1 edges, checking both sides of the boundary.
  task automatic ocp_window(input int ch, input logic [1:0] code);
    int lim;
    lim = BASE << code;
    tick(); deg = code; ovr[ch] = 1'b1; expect_now("R2 below window");
    for (int k = 1; k < lim; k++) begin
      tick(); expect_now("R2 below window");
    end
    tick(); e_ocp[ch] = 1'b1; expect_now("R2 qualified at window+1");
  endtask

  initial begin
    int lim;
    repeat (3) tick();
    rst = 1'b0;
    expect_now("R1 reset state");
    tick(); expect_now("R1 reset state");

    // Channel 0, shortest window
    ocp_window(0, 2'd0);
    tick(); ovr[0] = 1'b0; expect_now("R3 latched after flag drop, ch1 unaffected");
    tick(); clr_ocp[0] = 1'b1; e_ocp[0] = 1'b0; expect_now("R3 cleared by strobe");
    tick(); clr_ocp[0] = 1'b0; expect_now("R8 pin released");

    // Glitchy flag on code 1: two runs of exactly the window, split by a dip
    lim = BASE << 1;
    tick(); deg = 2'd1; ovr[0] = 1'b1; expect_now("R2 glitch run");
    for (int k = 1; k < lim; k++) begin tick(); expect_now("R2 glitch run"); end
    tick(); ovr[0] = 1'b0; expect_now("R2 dip restarts count");
    tick(); ovr[0] = 1'b1; expect_now("R2 glitch run");
    for (int k = 1; k < lim; k++) begin tick(); expect_now("R2 glitch run"); end
    tick(); ovr[0] = 1'b0; expect_now("R2 never qualified");

    // Channel 1, longest window, then clear while still high
    ocp_window(1, 2'd3);
    lim = BASE << 3;
    tick(); clr_ocp[1] = 1'b1; e_ocp[1] = 1'b0; expect_now("R3 clear while flag high");
    for (int k = 0; k < lim; k++) begin
      tick(); clr_ocp[1] = 1'b0; expect_now("R3 re-qualifying");
    end
    tick(); e_ocp[1] = 1'b1; expect_now("R3 set again after full window");
    tick(); ovr[1] = 1'b0; clr_ocp[1] = 1'b1; e_ocp[1] = 1'b0; expect_now("R3 clear");
    tick(); clr_ocp[1] = 1'b0; deg = 2'd0; expect_now("R3 idle");

    // Predriver fault on channel 1
    tick(); pdf[1] = 1'b1; e_pdf[1] = 1'b1; expect_now("R4 pdf set, ch0 on");
    tick(); clr_pdf[1] = 1'b1; expect_now("R4 flag beats clear");
    tick(); clr_pdf[1] = 1'b0; pdf[1] = 1'b0; expect_now("R4 latched");
    tick(); clr_pdf[1] = 1'b1; e_pdf[1] = 1'b0; expect_now("R4 cleared");
    tick(); clr_pdf[1] = 1'b0; expect_now("R4 idle");

    // Overtemperature
    tick(); ot = 1'b1; e_ot = 1'b1; expect_now("R5 both off");
    tick(); expect_now("R8 pin low on OT");
    tick(); ot = 1'b0; e_ot = 1'b0; expect_now("R5 self clear, R8 released");

    // Undervoltage across sleep
    tick(); uv = 1'b1; e_uv = 1'b1; expect_now("R6 uv set");
    tick(); uv = 1'b0; sleep_n = 1'b0; e_slp = 1'b1; expect_now("R6 held in sleep");
    tick(); expect_now("R6 held in sleep");
    tick(); sleep_n = 1'b1; e_slp = 1'b0; e_uv = 1'b0; expect_now("R6 cleared on wake");

    // Sleep keeps latched bits
    ocp_window(0, 2'd0);
    tick(); ovr[0] = 1'b0; sleep_n = 1'b0; e_slp = 1'b1; expect_now("R7 sleep off, bit kept");
    tick(); expect_now("R7 sleep off, bit kept");
    tick(); sleep_n = 1'b1; e_slp = 1'b0; expect_now("R7 wake, ch0 still latched");
    tick(); clr_ocp[0] = 1'b1; e_ocp[0] = 1'b0; expect_now("R3 clear");
    tick(); clr_ocp[0] = 1'b0; expect_now("R1 quiet");

    repeat (3) tick();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all R): actual=timeout expected=completion");
      report();
    end
  end

endmodule